// File: doc/BRIEF.md
# Auto-Increment Word Programming Sequencer

This block is the device-side controller for word-wise auto-increment programming in a serial flash. A front end delivers the bytes received while chip select is low. The sequencer recognises the frames, tracks the write-enable latch and the auto-increment mode flag, and drives a byte-store port into the array.

The first programming frame carries a start address and two data bytes. Every later frame carries only two data bytes, which go to the next even/odd address pair. After each pair the block stays busy for a fixed number of clock cycles. The mode ends when the host sends write-disable, or when the pair at the top of the array has been programmed.

While chip select is high, the block can optionally report ready/busy on the serial output pin. Protection decoding happens outside the block: it publishes the address it is about to program and reads back a single "locked" flag.

Top module: `aai_prog_seq`

## Requirements
- R1: After reset the mode flag, write-enable latch, busy flag, output enable and write strobe are all 0.
- R2: A one-byte frame with opcode 0x06 sets the write-enable latch. A start frame sent while the latch is clear is ignored: no byte is written and the mode flag stays 0.
- R3: A start frame has exactly six bytes: opcode 0xAD, three address bytes (most significant first, low ADDR_W bits used), data byte A, data byte B. With the latch set, it sets the mode flag and writes A to the address with bit 0 cleared and B to that address plus 1, in two consecutive cycles.
- R4: In the mode, a frame of exactly three bytes (0xAD, A, B) writes A and B to the pair that lies two above the previous pair.
- R5: The busy flag rises in the cycle after chip select rises at the end of an accepted frame and stays high for exactly PROG_CYCLES+2 cycles. A continuation frame that ends while busy is dropped: nothing is written and the address does not advance.
- R6: A one-byte frame with opcode 0x04 clears both the mode flag and the write-enable latch.
- R7: When targetLocked is high for the published targetAddr at the end of a start or continuation frame, that frame is ignored.
- R8: In the mode, every frame other than a continuation or 0x04 is ignored, and the next continuation still goes to the correct pair.
- R9: One-byte frames 0x70 and 0x80, sent outside the mode, enable and disable busy reporting. When reporting is enabled, the mode flag is set and chip select is high, soOe is 1 and soLevel is the inverse of busy. Whenever chip select is low, soOe is 0.
- R10: When the busy period for the top pair (all address bits 1 except bit 0) ends, the mode flag and the write-enable latch are cleared.
- R11: A frame whose byte count does not match its opcode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low, synchronous to clk |
| rxValid | input | 1 | One received byte is present this cycle |
| rxByte | input | 8 | Received byte |
| targetLocked | input | 1 | External protection verdict for targetAddr |
| targetAddr | output | ADDR_W | Even address that the next accepted frame would program |
| memWrEn | output | 1 | Byte-store strobe to the array |
| memAddr | output | ADDR_W | Byte-store address |
| memData | output | 8 | Byte-store data |
| busyFlag | output | 1 | Pair write and program time in progress |
| welFlag | output | 1 | Write-enable latch |
| aaiFlag | output | 1 | Auto-increment mode flag |
| soOe | output | 1 | Drive enable for the serial output pin |
| soLevel | output | 1 | Ready (1) or busy (0) level on the serial output pin |

## Verification
The hardest state to reach is a continuation frame that finishes while the previous pair is still busy. The bench therefore runs with a program time longer than a three-byte frame and sends the second frame immediately after the first. It then checks that no byte is written and that the following frame still lands on the next pair. Other states that need long setup are the automatic exit at the top pair and a lock that applies to only one pair in the middle of a run. The bench reaches them with a full sweep of a 64-byte array from mid-array to the top, setting the lock for one chosen pair partway through.

// File: rtl/aai_prog_pkg.sv
package aai_prog_pkg;
  localparam logic [7:0] OP_WREN     = 8'h06;
  localparam logic [7:0] OP_WRDI     = 8'h04;
  localparam logic [7:0] OP_AAI      = 8'hAD;
  localparam logic [7:0] OP_SOBSY_ON = 8'h70;
  localparam logic [7:0] OP_SOBSY_OF = 8'h80;

  localparam logic [2:0] LEN_START = 3'd6;
  localparam logic [2:0] LEN_NEXT  = 3'd3;
  localparam logic [2:0] LEN_CMD   = 3'd1;

  typedef struct packed {
    logic loadFirst;
    logic loadNext;
  } dpCmd_t;
endpackage

// File: rtl/aai_prog_dp.sv
module aai_prog_dp
  import aai_prog_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int PROG_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  dpCmd_t            cmd,
  output logic              frameEnd,
  output logic [7:0]        frameOp,
  output logic [2:0]        frameLen,
  output logic [ADDR_W-1:0] frameAddr,
  output logic [ADDR_W-1:0] nextAddr,
  output logic              busy,
  output logic              done,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 3);
  localparam logic [CNT_W-1:0] TOTAL = CNT_W'(PROG_CYCLES + 2);

  logic              csPrev;
  logic [2:0]        byteIdx;
  logic [7:0]        opReg;
  logic [ADDR_W-1:0] addrSh;
  logic [7:0]        dat0, dat1;
  logic [ADDR_W-1:0] wordAddr;
  logic [7:0]        wd0, wd1;
  logic [CNT_W-1:0]  cnt;

  // frame capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev  <= 1'b1;
      byteIdx <= '0;
      opReg   <= '0;
      addrSh  <= '0;
      dat0    <= '0;
      dat1    <= '0;
    end else begin
      csPrev <= csN;
      if (csN) begin
        byteIdx <= '0;
      end else if (rxValid) begin
        if (byteIdx == 3'd0) opReg <= rxByte;
        if (byteIdx >= 3'd1 && byteIdx <= 3'd3)
          addrSh <= ADDR_W'({addrSh, rxByte});
        dat0 <= dat1;
        dat1 <= rxByte;
        if (byteIdx != 3'd7) byteIdx <= byteIdx + 3'd1;
      end
    end
  end

  assign frameEnd  = csN & ~csPrev;
  assign frameOp   = opReg;
  assign frameLen  = byteIdx;
  assign frameAddr = addrSh & ~ADDR_W'(1);
  assign nextAddr  = wordAddr + ADDR_W'(2);

  // pair write and program-time counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordAddr <= '0;
      wd0      <= '0;
      wd1      <= '0;
      cnt      <= '0;
    end else if (cmd.loadFirst || cmd.loadNext) begin
      wordAddr <= cmd.loadFirst ? frameAddr : nextAddr;
      wd0      <= dat0;
      wd1      <= dat1;
      cnt      <= TOTAL;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign busy    = (cnt != '0);
  assign done    = (cnt == CNT_W'(1));
  assign memWrEn = (cnt == TOTAL) || (cnt == TOTAL - CNT_W'(1));
  assign memAddr = (cnt == TOTAL) ? wordAddr : (wordAddr | ADDR_W'(1));
  assign memData = (cnt == TOTAL) ? wd0 : wd1;
endmodule

// File: rtl/aai_prog_ctrl.sv
module aai_prog_ctrl
  import aai_prog_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              frameEnd,
  input  logic [7:0]        frameOp,
  input  logic [2:0]        frameLen,
  input  logic [ADDR_W-1:0] frameAddr,
  input  logic [ADDR_W-1:0] nextAddr,
  input  logic              busy,
  input  logic              done,
  input  logic              targetLocked,
  output logic [ADDR_W-1:0] targetAddr,
  output dpCmd_t            cmd,
  output logic              welFlag,
  output logic              aaiFlag,
  output logic              soOe,
  output logic              soLevel
);
  localparam logic [ADDR_W-1:0] TOP_PAIR = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic soEn, lastPair;
  logic isCmd;

  assign targetAddr = aaiFlag ? nextAddr : frameAddr;
  assign isCmd      = frameEnd && (frameLen == LEN_CMD);

  always_comb begin
    cmd = '0;
    if (frameEnd && frameOp == OP_AAI && !targetLocked) begin
      if (!aaiFlag && frameLen == LEN_START && welFlag) cmd.loadFirst = 1'b1;
      if (aaiFlag && frameLen == LEN_NEXT && !busy)     cmd.loadNext  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welFlag  <= 1'b0;
      aaiFlag  <= 1'b0;
      soEn     <= 1'b0;
      lastPair <= 1'b0;
    end else begin
      if (cmd.loadFirst) aaiFlag <= 1'b1;
      if (cmd.loadFirst || cmd.loadNext) lastPair <= (targetAddr == TOP_PAIR);
      if (isCmd && frameOp == OP_WRDI) begin
        welFlag  <= 1'b0;
        aaiFlag  <= 1'b0;
        lastPair <= 1'b0;
      end
      if (isCmd && !aaiFlag) begin
        if (frameOp == OP_WREN)     welFlag <= 1'b1;
        if (frameOp == OP_SOBSY_ON) soEn    <= 1'b1;
        if (frameOp == OP_SOBSY_OF) soEn    <= 1'b0;
      end
      if (done && lastPair) begin
        welFlag  <= 1'b0;
        aaiFlag  <= 1'b0;
        lastPair <= 1'b0;
      end
    end
  end

  assign soOe    = soEn & aaiFlag & csN;
  assign soLevel = ~busy;
endmodule

// File: rtl/aai_prog_seq.sv
module aai_prog_seq
  import aai_prog_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int PROG_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic              targetLocked,
  output logic [ADDR_W-1:0] targetAddr,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic              busyFlag,
  output logic              welFlag,
  output logic              aaiFlag,
  output logic              soOe,
  output logic              soLevel
);
  dpCmd_t            cmd;
  logic              frameEnd, done;
  logic [7:0]        frameOp;
  logic [2:0]        frameLen;
  logic [ADDR_W-1:0] frameAddr, nextAddr;

  aai_prog_dp #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) dp_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rxValid(rxValid), .rxByte(rxByte),
    .cmd(cmd), .frameEnd(frameEnd), .frameOp(frameOp), .frameLen(frameLen),
    .frameAddr(frameAddr), .nextAddr(nextAddr), .busy(busyFlag), .done(done),
    .memWrEn(memWrEn), .memAddr(memAddr), .memData(memData)
  );

  aai_prog_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .frameEnd(frameEnd), .frameOp(frameOp),
    .frameLen(frameLen), .frameAddr(frameAddr), .nextAddr(nextAddr),
    .busy(busyFlag), .done(done), .targetLocked(targetLocked),
    .targetAddr(targetAddr), .cmd(cmd), .welFlag(welFlag), .aaiFlag(aaiFlag),
    .soOe(soOe), .soLevel(soLevel)
  );
endmodule

// File: rtl/aai_prog_seq_chk.sv
module aai_prog_seq_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              busyFlag,
  input logic              welFlag,
  input logic              aaiFlag,
  input logic              soOe
);
  // R3: a byte store only happens inside a busy period
  assert_wr_in_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> busyFlag);

  // R3: the first store of a pair is at an even address
  assert_even_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && !$past(memWrEn)) |-> (memAddr[0] == 1'b0));

  // R3: the second store follows at the next address
  assert_pair_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && !$past(memWrEn)) |=> (memWrEn && memAddr == $past(memAddr) + ADDR_W'(1)));

  // R2: the mode flag never stands without the write-enable latch
  assert_mode_needs_wel_R2: assert property (@(posedge clk) disable iff (!rstN)
    aaiFlag |-> welFlag);

  // R9: the output pin is never driven while selected
  assert_so_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> !soOe);

  // R9: the pin reports only within the mode
  assert_so_in_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    soOe |-> aaiFlag);

  // R5: no store at the cycle busy drops
  assert_busy_end_clean_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyFlag) |-> !memWrEn);
endmodule

bind aai_prog_seq aai_prog_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .memWrEn(memWrEn), .memAddr(memAddr),
  .busyFlag(busyFlag), .welFlag(welFlag), .aaiFlag(aaiFlag), .soOe(soOe)
);

// File: tb/aai_prog_seq_tb_top.sv
module aai_prog_seq_tb_top;
  localparam int AW   = 6;
  localparam int PROG = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          csN = 1'b1;
  logic          rxValid = 1'b0;
  logic [7:0]    rxByte = '0;
  logic          targetLocked;
  logic [AW-1:0] targetAddr, memAddr;
  logic          memWrEn, busyFlag, welFlag, aaiFlag, soOe, soLevel;
  logic [7:0]    memData;
  logic [AW-1:0] blockAddr = 6'h3F;

  int checks = 0;
  int errors = 0;
  int wrCount = 0;
  logic [7:0] shadow [64];
  logic [7:0] fb [6];

  always #2.5 clk = ~clk;

  assign targetLocked = (targetAddr == blockAddr);

  aai_prog_seq #(.ADDR_W(AW), .PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rxValid(rxValid), .rxByte(rxByte),
    .targetLocked(targetLocked), .targetAddr(targetAddr), .memWrEn(memWrEn),
    .memAddr(memAddr), .memData(memData), .busyFlag(busyFlag),
    .welFlag(welFlag), .aaiFlag(aaiFlag), .soOe(soOe), .soLevel(soLevel)
  );

  always @(negedge clk) begin
    if (rstN && memWrEn) begin
      wrCount++;
      shadow[memAddr] = memData;
    end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 8'hFF);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendFrame(input int n);
    @(negedge clk);
    csN = 1'b0;
    for (int i = 0; i < n; i++) begin
      rxValid = 1'b1;
      rxByte  = fb[i];
      @(negedge clk);
    end
    rxValid = 1'b0;
    csN = 1'b1;
    @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    fb[0] = op;
    sendFrame(1);
  endtask

  task automatic startFrame(input int a);
    fb[0] = 8'hAD; fb[1] = 8'h00; fb[2] = 8'h00; fb[3] = 8'(a);
    fb[4] = pat(a & ~1); fb[5] = pat((a & ~1) + 1);
    sendFrame(6);
  endtask

  task automatic nextFrame(input int a);
    fb[0] = 8'hAD; fb[1] = pat(a); fb[2] = pat(a + 1);
    sendFrame(3);
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busyFlag) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n, base;
    for (int i = 0; i < 64; i++) shadow[i] = 8'hFF;
    repeat (3) @(negedge clk);
    check(aaiFlag == 0 && welFlag == 0 && busyFlag == 0 && soOe == 0 && memWrEn == 0,
          "R1 reset state", {aaiFlag, welFlag, busyFlag, soOe, memWrEn}, 0);
    rstN = 1'b1;
    @(negedge clk);

    startFrame(6'h20);
    repeat (PROG + 4) @(negedge clk);
    check(wrCount == 0 && aaiFlag == 0, "R2 start without latch ignored", wrCount, 0);

    fb[0] = 8'h06; fb[1] = 8'h00; sendFrame(2);
    check(welFlag == 0, "R11 two-byte enable frame ignored", welFlag, 0);

    cmd1(8'h06);
    check(welFlag == 1, "R2 enable frame sets latch", welFlag, 1);

    blockAddr = 6'h02;
    startFrame(6'h02);
    repeat (PROG + 4) @(negedge clk);
    check(wrCount == 0 && aaiFlag == 0 && welFlag == 1, "R7 locked start ignored", wrCount, 0);
    blockAddr = 6'h3F;

    fb[0] = 8'hAD; fb[1] = 0; fb[2] = 0; fb[3] = 8'h20; fb[4] = 8'h11; sendFrame(5);
    repeat (PROG + 4) @(negedge clk);
    check(wrCount == 0 && aaiFlag == 0, "R11 five-byte start ignored", wrCount, 0);

    cmd1(8'h70);
    startFrame(6'h21);
    check(aaiFlag == 1, "R3 mode flag set", aaiFlag, 1);
    check(soOe == 1 && soLevel == 0, "R9 busy shown on pin", {soOe, soLevel}, 2'b10);
    // second frame while still busy: dropped
    nextFrame(6'h22);
    waitIdle(n);
    check(shadow[6'h20] == pat(6'h20) && shadow[6'h21] == pat(6'h21) && wrCount == 2,
          "R3 first pair written", wrCount, 2);
    check(wrCount == 2, "R5 continuation while busy dropped", wrCount, 2);
    check(soOe == 1 && soLevel == 1, "R9 ready shown on pin", {soOe, soLevel}, 2'b11);
    @(negedge clk);
    csN = 1'b0;
    @(negedge clk);
    check(soOe == 0, "R9 pin released while selected", soOe, 0);
    csN = 1'b1;
    @(negedge clk);

    for (int a = 6'h22; a <= 6'h3E; a += 2) begin
      if (a == 6'h2A) begin
        base = wrCount;
        cmd1(8'h06);
        cmd1(8'h80);
        fb[0] = 8'hAD; fb[1] = 0; fb[2] = 0; fb[3] = 8'h10; sendFrame(4);
        startFrame(6'h10);
        repeat (PROG + 4) @(negedge clk);
        check(aaiFlag == 1 && wrCount == base, "R8 foreign frames ignored in mode", wrCount, base);
      end
      if (a == 6'h30) begin
        base = wrCount;
        blockAddr = 6'h30;
        nextFrame(a);
        repeat (PROG + 4) @(negedge clk);
        check(wrCount == base && aaiFlag == 1, "R7 locked continuation ignored", wrCount, base);
        blockAddr = 6'h3F;
      end
      base = wrCount;
      nextFrame(a);
      if (a == 6'h2A)
        check(soOe == 1, "R8 disable ignored in mode", soOe, 1);
      waitIdle(n);
      check(n == PROG + 2, "R5 busy length", n, PROG + 2);
      check(wrCount == base + 2 && shadow[a] == pat(a) && shadow[a + 1] == pat(a + 1),
            "R4 pair at next address", shadow[a], pat(a));
    end
    check(aaiFlag == 0 && welFlag == 0, "R10 exit after top pair", {aaiFlag, welFlag}, 0);

    cmd1(8'h06);
    startFrame(6'h10);
    waitIdle(n);
    check(shadow[6'h10] == pat(6'h10) && shadow[6'h11] == pat(6'h11), "R3 second session start",
          shadow[6'h10], pat(6'h10));
    cmd1(8'h04);
    check(aaiFlag == 0 && welFlag == 0, "R6 disable ends mode", {aaiFlag, welFlag}, 0);
    base = wrCount;
    nextFrame(6'h12);
    repeat (PROG + 4) @(negedge clk);
    check(wrCount == base, "R11 continuation outside mode ignored", wrCount, base);

    cmd1(8'h80);
    cmd1(8'h06);
    startFrame(6'h04);
    check(aaiFlag == 1 && busyFlag == 1 && soOe == 0, "R9 reporting disabled", soOe, 0);
    waitIdle(n);
    check(shadow[6'h04] == pat(6'h04) && shadow[6'h05] == pat(6'h05), "R3 pair at low address",
          shadow[6'h05], pat(6'h05));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule